// File: doc/BRIEF.md
# Three-Wire Synthesizer Control Register

This block is the control-word loader of a frequency synthesizer. A host writes it over a three-wire bus: an enable line that idles low, a serial clock, and a data line. While enable is high, every falling edge of the serial clock shifts in one data bit. The block commits fields to its outputs in stages as the bit count within the transfer reaches fixed points. The four band-switch bits are committed at bit 4. The 10-bit main counter and the 5-bit swallow counter are committed at bit 19. The 8-bit test field is committed at bit 27.

A short transfer therefore updates only the fields it has finished. A 4-bit transfer retunes the band switches alone. A 19-bit transfer sets the divider and returns the reference ratio to 1/640. A full 27-bit transfer also sets the test controls. The test field is decoded into charge-pump mode, monitor-pin selection, reference divide value, charge-pump current and tuning-amplifier enable.

The serial pins are sampled in the system clock domain and are assumed to be already synchronised and deglitched. The active-low reset stands for power-on reset and loads the defaults.

Top module: `synth_ctl_reg`

## Requirements
- R1: A bit is taken only on a falling edge of `ser_clk` seen while `ser_en` is high. A rising edge of `ser_en` clears the bit count, so each transfer begins at bit 1. Clock edges while `ser_en` is low change nothing.
- R2: The first four bits of a transfer form `band_on`, with the first bit landing in `band_on[3]`. `band_on` updates within two system clocks of the fourth falling edge, while the transfer is still in progress.
- R3: Bits 5 to 19 are main_div[9] down to main_div[0], then swallow_div[4] down to swallow_div[0]. Both counters are committed only at the 19th falling edge. That same commit clears `test_ctl[2:1]`, which sets the reference ratio to 640.
- R4: If `ser_en` falls before the 19th bit, only the band field (when at least four bits arrived) is updated. `main_div`, `swallow_div` and `test_ctl` keep their values.
- R5: Bits 20 to 27 form `test_ctl`, from test_ctl[7] down to test_ctl[0], and are committed at the 27th falling edge. Bit 6 is the current select, bits 5..3 the mode, bits 2..1 the ratio select and bit 0 the amplifier disable.
- R6: Falling edges after the 27th in a transfer change no output.
- R7: Reset sets `band_on` to 0, `main_div` and `swallow_div` to 0, and `test_ctl` to 8'b1101_0001. That gives the high current, a high-impedance pump, the lock monitor, ratio 640 and the amplifier off.
- R8: `pump_mode` (0 normal, 1 high impedance, 2 sink, 3 source) and `mon_sel` (0 lock, 1 reference, 2 divider) decode from test_ctl[5:3] as follows: 00x gives 0/0; 01x gives 1/0; 110 gives 2/0; 111 gives 3/0; 100 gives 1/1; 101 gives 1/2.
- R9: `ref_div` is 640 when test_ctl[1]=0, 512 when test_ctl[2:1]=11, and 1024 when test_ctl[2:1]=01. `cp_high` equals test_ctl[6] and `tune_on` is the inverse of test_ctl[0].
- R10: `band_overload` is high exactly when three or more bits of `band_on` are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| ser_en | input | 1 | Serial enable, idles low |
| ser_clk | input | 1 | Serial clock, data taken on its falling edge |
| ser_dat | input | 1 | Serial data |
| band_on | output | 4 | Band switch drives, 1 = on |
| band_overload | output | 1 | Three or more band switches on |
| main_div | output | 10 | Main counter value |
| swallow_div | output | 5 | Swallow counter value |
| test_ctl | output | 8 | Committed test field |
| pump_mode | output | 2 | Charge-pump state |
| mon_sel | output | 2 | Monitor pin selection |
| ref_div | output | 11 | Reference divide value |
| cp_high | output | 1 | High charge-pump current selected |
| tune_on | output | 1 | Tuning amplifier enabled |

## Verification
The assertions check, on every cycle, that no field moves unless enable was high in the cycle before. They also check that any divider change arrives with the reference ratio at 640, that a non-lock monitor selection always comes with a high-impedance pump, that the ratio is always one of the three legal values, and that the overload flag never rises without three active band bits. Only the bench scenarios can show the bit ordering of each field, the staged commit points, discarding after an early enable drop, and the rejection of extra clocks, because these depend on the sequence of serial edges. Constrained random transfer lengths, mixed with directed cases, exercise each of these.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

   typedef enum logic [1:0] {
      PUMP_NORMAL = 2'd0,
      PUMP_HIZ    = 2'd1,
      PUMP_SINK   = 2'd2,
      PUMP_SOURCE = 2'd3
   } pump_mode_e;

   typedef enum logic [1:0] {
      MON_LOCK = 2'd0,
      MON_REF  = 2'd1,
      MON_DIV  = 2'd2
   } mon_sel_e;

   localparam int REF_DIV_W = 11;

   // test field bit positions (fixed by the serial ordering)
   localparam int TB_CP  = 6;
   localparam int TB_T2  = 5;
   localparam int TB_T1  = 4;
   localparam int TB_T0  = 3;
   localparam int TB_RSA = 2;
   localparam int TB_RSB = 1;
   localparam int TB_OS  = 0;

   localparam logic [7:0] TEST_RESET = 8'b1101_0001;

endpackage

// File: rtl/sctl_bit_counter.sv
module sctl_bit_counter #(
   parameter int LAST_BIT = 27,
   localparam int CW = $clog2(LAST_BIT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ser_en,
   input  logic          ser_clk,
   output logic          take,
   output logic [CW-1:0] idx
);

   logic          sclk_q, en_q;
   logic [CW-1:0] cnt;
   logic          start, fall;

   assign start = ser_en & ~en_q;
   assign fall  = sclk_q & ~ser_clk;
   assign take  = ser_en & fall & ~start & (cnt < CW'(LAST_BIT));
   assign idx   = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         en_q   <= 1'b0;
         cnt    <= '0;
      end else begin
         sclk_q <= ser_clk;
         en_q   <= ser_en;
         if (start)     cnt <= '0;
         else if (take) cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/sctl_shifter.sv
module sctl_shifter #(
   parameter int W = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         take,
   input  logic         din,
   output logic [W-1:0] q
);

   generate
      if (W == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    q <= '0;
            else if (take) q <= din;
         end
      end else begin : g_wide
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    q <= '0;
            else if (take) q <= {q[W-2:0], din};
         end
      end
   endgenerate

endmodule

// File: rtl/sctl_field_bank.sv
module sctl_field_bank
   import sctl_pkg::*;
#(
   parameter int BAND_W = 4,
   parameter int MAIN_W = 10,
   parameter int SWAL_W = 5,
   parameter int TEST_W = 8,
   parameter int SH_W   = 14,
   parameter int CW     = 5,
   localparam int DIV_W   = MAIN_W + SWAL_W,
   localparam int BAND_AT = BAND_W - 1,
   localparam int DIV_AT  = BAND_W + DIV_W - 1,
   localparam int TEST_AT = DIV_AT + TEST_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [CW-1:0]     idx,
   input  logic              din,
   input  logic [SH_W-1:0]   sh,
   output logic [BAND_W-1:0] band,
   output logic [MAIN_W-1:0] main_v,
   output logic [SWAL_W-1:0] swal_v,
   output logic [TEST_W-1:0] test_v
);

   logic [SH_W:0] frame;
   assign frame = {sh, din};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         band   <= '0;
         main_v <= '0;
         swal_v <= '0;
         test_v <= TEST_RESET;
      end else if (take) begin
         if (idx == CW'(BAND_AT)) band <= frame[BAND_W-1:0];
         if (idx == CW'(DIV_AT)) begin
            {main_v, swal_v} <= frame[DIV_W-1:0];
            test_v[TB_RSA]   <= 1'b0;
            test_v[TB_RSB]   <= 1'b0;
         end
         if (idx == CW'(TEST_AT)) test_v <= frame[TEST_W-1:0];
      end
   end

endmodule

// File: rtl/sctl_decode.sv
module sctl_decode
   import sctl_pkg::*;
#(
   parameter int BAND_W = 4
) (
   input  logic [6:0]           tst,
   input  logic [BAND_W-1:0]    band,
   output logic [1:0]           pump_mode,
   output logic [1:0]           mon_sel,
   output logic [REF_DIV_W-1:0] ref_div,
   output logic                 cp_high,
   output logic                 tune_on,
   output logic                 overload
);

   pump_mode_e pm;
   mon_sel_e   ms;

   always_comb begin
      pm = PUMP_NORMAL;
      ms = MON_LOCK;
      case ({tst[TB_T2], tst[TB_T1], tst[TB_T0]})
         3'b000, 3'b001: pm = PUMP_NORMAL;
         3'b010, 3'b011: pm = PUMP_HIZ;
         3'b110:         pm = PUMP_SINK;
         3'b111:         pm = PUMP_SOURCE;
         3'b100: begin pm = PUMP_HIZ; ms = MON_REF; end
         default: begin pm = PUMP_HIZ; ms = MON_DIV; end
      endcase
   end

   always_comb begin
      if (!tst[TB_RSB])     ref_div = REF_DIV_W'(640);
      else if (tst[TB_RSA]) ref_div = REF_DIV_W'(512);
      else                  ref_div = REF_DIV_W'(1024);
   end

   assign pump_mode = pm;
   assign mon_sel   = ms;
   assign cp_high   = tst[TB_CP];
   assign tune_on   = ~tst[TB_OS];

   generate
      if (BAND_W >= 3) begin : g_ovl
         assign overload = ($countones(band) >= 3);
      end else begin : g_no_ovl
         assign overload = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/synth_ctl_reg.sv
module synth_ctl_reg
   import sctl_pkg::*;
#(
   parameter int BAND_W = 4,
   parameter int MAIN_W = 10,
   parameter int SWAL_W = 5,
   parameter int TEST_W = 8,
   localparam int DIV_W    = MAIN_W + SWAL_W,
   localparam int LAST_BIT = BAND_W + DIV_W + TEST_W,
   localparam int SH_W     = ((DIV_W > TEST_W) ? DIV_W : TEST_W) - 1,
   localparam int CW       = $clog2(LAST_BIT + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ser_en,
   input  logic                 ser_clk,
   input  logic                 ser_dat,
   output logic [BAND_W-1:0]    band_on,
   output logic                 band_overload,
   output logic [MAIN_W-1:0]    main_div,
   output logic [SWAL_W-1:0]    swallow_div,
   output logic [TEST_W-1:0]    test_ctl,
   output logic [1:0]           pump_mode,
   output logic [1:0]           mon_sel,
   output logic [REF_DIV_W-1:0] ref_div,
   output logic                 cp_high,
   output logic                 tune_on
);

   generate
      if (TEST_W != 8) begin : g_bad_test
         $error("synth_ctl_reg: TEST_W must be 8");
      end
      if (BAND_W < 1 || MAIN_W < 1 || SWAL_W < 1) begin : g_bad_w
         $error("synth_ctl_reg: field widths must be positive");
      end
      if (BAND_W > SH_W + 1) begin : g_bad_band
         $error("synth_ctl_reg: band field wider than frame");
      end
   endgenerate

   logic          take;
   logic [CW-1:0] idx;
   logic [SH_W-1:0] sh;

   sctl_bit_counter #(.LAST_BIT(LAST_BIT)) u_cnt (
      .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk),
      .take(take), .idx(idx)
   );

   sctl_shifter #(.W(SH_W)) u_sh (
      .clk(clk), .rst_n(rst_n), .take(take), .din(ser_dat), .q(sh)
   );

   sctl_field_bank #(
      .BAND_W(BAND_W), .MAIN_W(MAIN_W), .SWAL_W(SWAL_W),
      .TEST_W(TEST_W), .SH_W(SH_W), .CW(CW)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .take(take), .idx(idx), .din(ser_dat),
      .sh(sh), .band(band_on), .main_v(main_div), .swal_v(swallow_div),
      .test_v(test_ctl)
   );

   sctl_decode #(.BAND_W(BAND_W)) u_dec (
      .tst(test_ctl[6:0]), .band(band_on), .pump_mode(pump_mode),
      .mon_sel(mon_sel), .ref_div(ref_div), .cp_high(cp_high),
      .tune_on(tune_on), .overload(band_overload)
   );

endmodule

// File: rtl/sctl_checker.sv
module sctl_checker #(
   parameter int BAND_W = 4,
   parameter int MAIN_W = 10,
   parameter int SWAL_W = 5,
   parameter int TEST_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ser_en,
   input logic [BAND_W-1:0] band_on,
   input logic              band_overload,
   input logic [MAIN_W-1:0] main_div,
   input logic [SWAL_W-1:0] swallow_div,
   input logic [TEST_W-1:0] test_ctl,
   input logic [1:0]        pump_mode,
   input logic [1:0]        mon_sel,
   input logic [10:0]       ref_div
);

   // R1/R4: with enable low nothing may move
   a_r1_band_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ser_en) |-> $stable(band_on));

   a_r4_div_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ser_en) |-> ($stable(main_div) && $stable(swallow_div)));

   a_r5_test_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ser_en) |-> $stable(test_ctl));

   a_r3_div_sets_640: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({main_div, swallow_div}) |-> (ref_div == 11'd640));

   a_r8_monitor_hiz: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_sel != 2'd0) |-> (pump_mode == 2'd1));

   a_r9_ratio_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_div == 11'd640) || (ref_div == 11'd512) || (ref_div == 11'd1024));

   a_r10_overload: assert property (@(posedge clk) disable iff (!rst_n)
      band_overload |-> ($countones(band_on) >= 3));

endmodule

bind synth_ctl_reg sctl_checker #(
   .BAND_W(BAND_W), .MAIN_W(MAIN_W), .SWAL_W(SWAL_W), .TEST_W(TEST_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .band_on(band_on),
   .band_overload(band_overload), .main_div(main_div),
   .swallow_div(swallow_div), .test_ctl(test_ctl), .pump_mode(pump_mode),
   .mon_sel(mon_sel), .ref_div(ref_div)
);

// File: tb/sim_synth_ctl_reg.sv
`timescale 1ns/1ps
module sim_synth_ctl_reg;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_en = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
   logic [3:0]  band_on;
   logic        band_overload;
   logic [9:0]  main_div;
   logic [4:0]  swallow_div;
   logic [7:0]  test_ctl;
   logic [1:0]  pump_mode, mon_sel;
   logic [10:0] ref_div;
   logic        cp_high, tune_on;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   logic [3:0] e_band;
   logic [9:0] e_m;
   logic [4:0] e_s;
   logic [7:0] e_t;

   always #4 clk = ~clk;

   synth_ctl_reg u0 (
      .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk),
      .ser_dat(ser_dat), .band_on(band_on), .band_overload(band_overload),
      .main_div(main_div), .swallow_div(swallow_div), .test_ctl(test_ctl),
      .pump_mode(pump_mode), .mon_sel(mon_sel), .ref_div(ref_div),
      .cp_high(cp_high), .tune_on(tune_on)
   );

   function automatic int f_pump(logic [7:0] t);
      case (t[5:3])
         3'b000, 3'b001: return 0;
         3'b010, 3'b011: return 1;
         3'b110:         return 2;
         3'b111:         return 3;
         default:        return 1;
      endcase
   endfunction

   function automatic int f_mon(logic [7:0] t);
      if (t[5:3] == 3'b100) return 1;
      if (t[5:3] == 3'b101) return 2;
      return 0;
   endfunction

   function automatic int f_ref(logic [7:0] t);
      if (!t[1]) return 640;
      return t[2] ? 512 : 1024;
   endfunction

   function automatic int f_ones(logic [3:0] b);
      return int'(b[0]) + int'(b[1]) + int'(b[2]) + int'(b[3]);
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_all(input string req);
      chk(req, "band_on", int'(band_on), int'(e_band));
      chk(req, "main_div", int'(main_div), int'(e_m));
      chk(req, "swallow_div", int'(swallow_div), int'(e_s));
      chk(req, "test_ctl", int'(test_ctl), int'(e_t));
      chk("R8", "pump_mode", int'(pump_mode), f_pump(e_t));
      chk("R8", "mon_sel", int'(mon_sel), f_mon(e_t));
      chk("R9", "ref_div", int'(ref_div), f_ref(e_t));
      chk("R9", "cp_high", int'(cp_high), int'(e_t[6]));
      chk("R9", "tune_on", int'(tune_on), int'(!e_t[0]));
      chk("R10", "band_overload", int'(band_overload), int'(f_ones(e_band) >= 3));
   endtask

   // w[26] is the first bit sent; bits beyond 27 are random filler
   task automatic xfer(input int n, input logic [26:0] w, input string req);
      ser_en = 1'b1;
      wait_clks(3);
      for (int k = 0; k < n; k++) begin
         ser_dat = (k < 27) ? w[26-k] : 1'($urandom);
         ser_clk = 1'b1;
         wait_clks(4);
         ser_clk = 1'b0;
         wait_clks(4);
         if (k == 3) begin
            e_band = w[26:23];
            chk("R2", "band mid-transfer", int'(band_on), int'(e_band));
            chk("R3", "divider held mid-transfer", int'(main_div), int'(e_m));
         end
      end
      ser_en = 1'b0;
      wait_clks(4);
      if (n >= 19) begin
         e_m = w[22:13];
         e_s = w[12:8];
         e_t[2:1] = 2'b00;
      end
      if (n >= 27) e_t = w[7:0];
      check_all(req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      e_band = 4'd0; e_m = 10'd0; e_s = 5'd0; e_t = 8'b1101_0001;
      wait_clks(5);
      rst_n = 1'b1;
      wait_clks(3);
      check_all("R7");
      chk("R7", "ref_div reset", int'(ref_div), 640);
      chk("R7", "pump hiz reset", int'(pump_mode), 1);

      // R5/R8/R9: source mode, ratio 512
      xfer(27, {4'b0001, 10'd700, 5'd17, 8'b1011_1110}, "R5");
      // R8/R9: divider monitor, ratio 1024, low current, amp off
      xfer(27, {4'b0010, 10'd1023, 5'd31, 8'b1010_1011}, "R5");
      // R3: 19-bit transfer forces ratio back to 640, keeps other test bits
      xfer(27, {4'b0100, 10'd32, 5'd0, 8'b1111_0110}, "R5");
      xfer(19, {4'b1000, 10'd555, 5'd9, 8'h00}, "R3");
      chk("R3", "ratio forced 640", int'(ref_div), 640);
      // R6: extra clocks ignored
      xfer(31, {4'b0011, 10'd100, 5'd3, 8'b1000_0000}, "R6");
      // R4: early drop after 10 bits keeps divider
      xfer(10, {4'b0101, 10'd999, 5'd1, 8'hFF}, "R4");
      // R4: drop after 3 bits changes nothing
      xfer(3, {4'b1111, 10'd5, 5'd5, 8'hFF}, "R4");
      // R10: three bands on
      xfer(4, {4'b0111, 23'd0}, "R10");
      xfer(4, {4'b1111, 23'd0}, "R10");
      // R1: clock pulses with enable low change nothing
      for (int k = 0; k < 30; k++) begin
         ser_dat = 1'($urandom);
         ser_clk = 1'b1; wait_clks(2);
         ser_clk = 1'b0; wait_clks(2);
      end
      check_all("R1");
      // R1: a fresh transfer starts at bit 1 after the disabled pulses
      xfer(19, {4'b1001, 10'd321, 5'd30, 8'h00}, "R1");

      // random transfers
      for (int i = 0; i < 60; i++) begin
         int n;
         logic [26:0] w;
         n = int'($urandom_range(0, 31));
         w = 27'($urandom);
         if (n >= 27) w[5:3] = 3'($urandom);
         xfer(n, w, (n >= 27) ? "R5" : (n >= 19) ? "R3" : "R4");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule